// File: doc/BRIEF.md
# Expansion-to-Local Time Slot Selector

This block builds a local output frame of 32 byte-wide channels. It takes each byte from an expansion bus that carries up to 16 parallel byte streams, each with 128 time slots per frame. For every local channel, a routing table names one expansion (stream, slot) pair. On the matching expansion slot, the block copies the byte from the named stream into that channel's working register.

When the last slot of an expansion frame arrives, all working registers are copied at once into a presentation bank. The local side then reads out a complete, consistent set of bytes from the last finished expansion frame. It reads them channel by channel, one channel per local strobe.

A host loads the table through a byte-wide write port with an 8-bit address. The host first writes the slot number as a low byte, which is held pending. It then writes the stream number as a high byte to the channel's address, and that write commits the whole entry.

Top module: `exp_slot_selector`

## Requirements
- R1: After reset every routing entry is stream 0, slot 0, and the presentation bank and `loc_data` are zero. The first complete expansion frame therefore places the byte of stream 0, slot 0 on every local channel.
- R2: A write with `host_hi`=0 to address 0xA0+N (N from 0 to 31) stores `host_data[6:0]` as the pending slot number. `host_data[7]` is ignored.
- R3: A write with `host_hi`=1 to address 0xA0+N sets entry N to stream `host_data[3:0]` and slot equal to the pending slot number. `host_data[7:4]` is ignored. A low-byte write on its own leaves every entry unchanged.
- R4: A write to any address below 0xA0 or above 0xBF changes neither the routing entries nor the pending slot number.
- R5: Local channel N carries the byte that stream S held in slot T of the expansion frame, where (S, T) is entry N. Several channels may name the same source, including the last slot, 127.
- R6: The presentation bank changes only on the beat of expansion slot 127. Until then, local output shows the previous complete frame, even while a later frame is partly received.
- R7: An expansion beat with `exp_fs`=1 is slot 0. Each further beat with `exp_valid`=1 is the next slot. After slot 127 the count returns to 0 without `exp_fs`.
- R8: A local beat (`loc_valid`=1) with `loc_fs`=1 reads channel 0, and later beats read the following channels, wrapping after 31. The byte appears on `loc_data` with `loc_out_valid`=1 one cycle after the beat. With no beat, `loc_out_valid` is 0 and `loc_data` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_hi | input | 1 | 0: low (slot) byte, 1: high (stream) byte and commit |
| host_addr | input | 8 | Host internal address |
| host_data | input | 8 | Host write data |
| exp_valid | input | 1 | One expansion slot present this cycle |
| exp_fs | input | 1 | This expansion beat is slot 0 |
| exp_data | input | 128 | Byte of stream s on bits [8s+7:8s] |
| loc_valid | input | 1 | Local channel read strobe |
| loc_fs | input | 1 | This local beat is channel 0 |
| loc_data | output | 8 | Local channel byte |
| loc_out_valid | output | 1 | `loc_data` updated this cycle |

## Verification
The assertions check several rules on every cycle. They confirm that commits take their stream and pending slot from the right write, that out-of-range and low-byte writes leave the table alone, and that the presentation bank stays still when no expansion beat arrives. They also cover the slot counter's start, step and wrap, and the one-cycle latency and hold of the local output. Only the bench's scenarios can show the end-to-end mapping of real data. That includes multicast to a shared source, the reserved bits, and the pending slot surviving ignored writes. It also includes the local frame still showing the old frame while a new one is half received.

// File: rtl/slot_sel_pkg.sv
package slot_sel_pkg;
   localparam int SLOT_W = 7;
   localparam int STRM_W = 4;
   localparam int HOST_W = 8;

   typedef struct packed {
      logic [STRM_W-1:0] strm;
      logic [SLOT_W-1:0] slot;
   } route_t;
endpackage

// File: rtl/slot_sel_route_mem.sv
module slot_sel_route_mem
   import slot_sel_pkg::*;
#(
   parameter int NUM_CHAN  = 32,
   parameter int ADDR_W    = 8,
   parameter int BASE_ADDR = 'hA0
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic                      wr_hi,
   input  logic [ADDR_W-1:0]         wr_addr,
   input  logic [HOST_W-1:0]         wr_data,
   output route_t [NUM_CHAN-1:0]     route_o
);
   localparam int CH_W = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1;
   localparam logic [ADDR_W:0] BASE_EXT = (ADDR_W+1)'(BASE_ADDR);
   localparam logic [ADDR_W:0] CHAN_LIM = (ADDR_W+1)'(NUM_CHAN);

   logic [ADDR_W:0]   off;
   logic              hit;
   logic [CH_W-1:0]   idx;
   logic [SLOT_W-1:0] pend_q;
   route_t [NUM_CHAN-1:0] route_q;

   // address window decode: negative or too-large offsets miss
   assign off = {1'b0, wr_addr} - BASE_EXT;
   assign hit = wr_en && !off[ADDR_W] && (off < CHAN_LIM);
   assign idx = off[CH_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n)
         pend_q <= '0;
      else if (hit && !wr_hi)
         pend_q <= wr_data[SLOT_W-1:0];
   end

   for (genvar c = 0; c < NUM_CHAN; c++) begin : g_entry
      always_ff @(posedge clk) begin
         if (!rst_n)
            route_q[c] <= '0;
         else if (hit && wr_hi && idx == CH_W'(c))
            route_q[c] <= '{strm: wr_data[STRM_W-1:0], slot: pend_q};
      end

      p_commit_strm_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && wr_hi && int'(wr_addr) == BASE_ADDR + c)
         |=> route_q[c].strm == $past(wr_data[STRM_W-1:0]));
      p_commit_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && wr_hi && int'(wr_addr) == BASE_ADDR + c)
         |=> route_q[c].slot == $past(pend_q));
   end

   assign route_o = route_q;

   p_out_of_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (int'(wr_addr) < BASE_ADDR || int'(wr_addr) >= BASE_ADDR + NUM_CHAN))
      |=> ($stable(route_q) && $stable(pend_q)));
   p_low_no_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_hi) |=> $stable(route_q));
   p_pend_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_hi && int'(wr_addr) >= BASE_ADDR && int'(wr_addr) < BASE_ADDR + NUM_CHAN)
      |=> pend_q == $past(wr_data[SLOT_W-1:0]));
endmodule

// File: rtl/slot_sel_capture.sv
module slot_sel_capture
   import slot_sel_pkg::*;
#(
   parameter int NUM_CHAN    = 32,
   parameter int NUM_STREAMS = 16,
   parameter int NUM_SLOTS   = 128,
   parameter int DATA_W      = 8
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  route_t [NUM_CHAN-1:0]                route_i,
   input  logic                                 exp_valid,
   input  logic                                 exp_fs,
   input  logic [NUM_STREAMS-1:0][DATA_W-1:0]   exp_data,
   output logic [NUM_CHAN-1:0][DATA_W-1:0]      held_o
);
   localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);

   logic [SLOT_W-1:0] slot_q;
   logic [SLOT_W-1:0] cur;
   logic              frame_end;
   logic [NUM_CHAN-1:0][DATA_W-1:0] work_q;
   logic [NUM_CHAN-1:0][DATA_W-1:0] work_nxt;
   logic [NUM_CHAN-1:0][DATA_W-1:0] held_q;

   assign cur       = exp_fs ? '0 : slot_q;
   assign frame_end = exp_valid && (cur == LAST_SLOT);

   always_ff @(posedge clk) begin
      if (!rst_n)
         slot_q <= '0;
      else if (exp_valid)
         slot_q <= frame_end ? '0 : cur + 1'b1;
   end

   for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
      logic [DATA_W-1:0] pick;
      always_comb begin
         pick = '0;
         if (int'(route_i[c].strm) < NUM_STREAMS)
            pick = exp_data[route_i[c].strm];
         work_nxt[c] = (exp_valid && route_i[c].slot == cur) ? pick : work_q[c];
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            work_q[c] <= '0;
            held_q[c] <= '0;
         end else begin
            work_q[c] <= work_nxt[c];
            if (frame_end)
               held_q[c] <= work_nxt[c];
         end
      end
   end

   assign held_o = held_q;

   p_bank_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !exp_valid |=> $stable(held_q));
   p_bank_midframe_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (exp_valid && exp_fs) |=> $stable(held_q));
   p_fs_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (exp_valid && exp_fs) |=> slot_q == SLOT_W'(1));
   p_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (exp_valid && !exp_fs && slot_q != LAST_SLOT)
      |=> slot_q == SLOT_W'($past(slot_q) + 1'b1));
   p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (exp_valid && !exp_fs && slot_q == LAST_SLOT) |=> slot_q == '0);
endmodule

// File: rtl/slot_sel_out.sv
module slot_sel_out #(
   parameter int NUM_CHAN = 32,
   parameter int DATA_W   = 8
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             loc_valid,
   input  logic                             loc_fs,
   input  logic [NUM_CHAN-1:0][DATA_W-1:0]  held_i,
   output logic [DATA_W-1:0]                loc_data,
   output logic                             loc_out_valid
);
   localparam int CH_W = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1;
   localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CHAN - 1);

   logic [CH_W-1:0] ch_q;
   logic [CH_W-1:0] ch_cur;

   assign ch_cur = loc_fs ? '0 : ch_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ch_q          <= '0;
         loc_data      <= '0;
         loc_out_valid <= 1'b0;
      end else begin
         loc_out_valid <= loc_valid;
         if (loc_valid) begin
            loc_data <= held_i[ch_cur];
            ch_q     <= (ch_cur == LAST_CH) ? '0 : ch_cur + 1'b1;
         end
      end
   end

   p_out_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
      loc_valid |=> loc_out_valid);
   p_out_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !loc_valid |=> (!loc_out_valid && $stable(loc_data)));
   p_out_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (loc_valid && loc_fs) |=> loc_data == $past(held_i[0]));
endmodule

// File: rtl/exp_slot_selector.sv
module exp_slot_selector
   import slot_sel_pkg::*;
#(
   parameter int NUM_CHAN    = 32,
   parameter int NUM_STREAMS = 16,
   parameter int NUM_SLOTS   = 128,
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 8,
   parameter int BASE_ADDR   = 'hA0
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          host_wr,
   input  logic                          host_hi,
   input  logic [ADDR_W-1:0]             host_addr,
   input  logic [HOST_W-1:0]             host_data,
   input  logic                          exp_valid,
   input  logic                          exp_fs,
   input  logic [NUM_STREAMS*DATA_W-1:0] exp_data,
   input  logic                          loc_valid,
   input  logic                          loc_fs,
   output logic [DATA_W-1:0]             loc_data,
   output logic                          loc_out_valid
);
   localparam int CH_W = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1;

   if (NUM_STREAMS < 1 || NUM_STREAMS > (1 << STRM_W)) begin : g_bad_streams
      $error("NUM_STREAMS out of range for the stream field");
   end
   if (NUM_SLOTS < 2 || NUM_SLOTS > (1 << SLOT_W)) begin : g_bad_slots
      $error("NUM_SLOTS out of range for the slot field");
   end
   if (NUM_CHAN < 2 || CH_W > ADDR_W || BASE_ADDR + NUM_CHAN > (1 << ADDR_W)) begin : g_bad_window
      $error("routing window does not fit the host address space");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("DATA_W must be positive");
   end

   route_t [NUM_CHAN-1:0]                 route;
   logic [NUM_STREAMS-1:0][DATA_W-1:0]    exp_arr;
   logic [NUM_CHAN-1:0][DATA_W-1:0]       held;

   assign exp_arr = exp_data;

   slot_sel_route_mem #(
      .NUM_CHAN  (NUM_CHAN),
      .ADDR_W    (ADDR_W),
      .BASE_ADDR (BASE_ADDR)
   ) u_route (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (host_wr),
      .wr_hi   (host_hi),
      .wr_addr (host_addr),
      .wr_data (host_data),
      .route_o (route)
   );

   slot_sel_capture #(
      .NUM_CHAN    (NUM_CHAN),
      .NUM_STREAMS (NUM_STREAMS),
      .NUM_SLOTS   (NUM_SLOTS),
      .DATA_W      (DATA_W)
   ) u_capture (
      .clk       (clk),
      .rst_n     (rst_n),
      .route_i   (route),
      .exp_valid (exp_valid),
      .exp_fs    (exp_fs),
      .exp_data  (exp_arr),
      .held_o    (held)
   );

   slot_sel_out #(
      .NUM_CHAN (NUM_CHAN),
      .DATA_W   (DATA_W)
   ) u_out (
      .clk           (clk),
      .rst_n         (rst_n),
      .loc_valid     (loc_valid),
      .loc_fs        (loc_fs),
      .held_i        (held),
      .loc_data      (loc_data),
      .loc_out_valid (loc_out_valid)
   );
endmodule

// File: tb/exp_slot_selector_tb.sv
`timescale 1ns/1ps
module exp_slot_selector_tb;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         host_wr = 1'b0, host_hi = 1'b0;
   logic [7:0]   host_addr = '0, host_data = '0;
   logic         exp_valid = 1'b0, exp_fs = 1'b0;
   logic [127:0] exp_data = '0;
   logic         loc_valid = 1'b0, loc_fs = 1'b0;
   logic [7:0]   loc_data;
   logic         loc_out_valid;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   int m_strm [32];
   int m_slot [32];
   int m_pend = 0;

   always #4 clk = ~clk;

   exp_slot_selector u_dut (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_hi(host_hi),
      .host_addr(host_addr), .host_data(host_data), .exp_valid(exp_valid),
      .exp_fs(exp_fs), .exp_data(exp_data), .loc_valid(loc_valid),
      .loc_fs(loc_fs), .loc_data(loc_data), .loc_out_valid(loc_out_valid)
   );

   function automatic logic [7:0] src_byte(int s, int t, int k);
      return 8'((s * 37 + t * 5 + k * 101 + 1) & 255);
   endfunction

   task automatic chk(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic host_write(bit hi, int addr, int data);
      host_wr = 1'b1; host_hi = hi; host_addr = 8'(addr); host_data = 8'(data);
      @(negedge clk);
      host_wr = 1'b0;
      if (addr >= 'hA0 && addr <= 'hBF) begin
         if (!hi) m_pend = data & 'h7F;
         else begin
            m_strm[addr - 'hA0] = data & 'hF;
            m_slot[addr - 'hA0] = m_pend;
         end
      end
   endtask

   // beats for slots first..first+n-1 carrying frame tag k
   task automatic exp_beats(int k, int first, int n, bit fs);
      for (int t = first; t < first + n; t++) begin
         exp_valid = 1'b1;
         exp_fs = fs && (t == first);
         for (int s = 0; s < 16; s++) exp_data[s*8 +: 8] = src_byte(s, t, k);
         @(negedge clk);
      end
      exp_valid = 1'b0; exp_fs = 1'b0;
   endtask

   task automatic local_frame(int k, bit fs, bit zero, string req);
      for (int c = 0; c < 32; c++) begin
         loc_valid = 1'b1;
         loc_fs = fs && (c == 0);
         @(negedge clk);
         chk(loc_out_valid == 1'b1, req, loc_out_valid, 1);
         if (zero) chk(loc_data == 8'h00, req, loc_data, 0);
         else chk(loc_data == src_byte(m_strm[c], m_slot[c], k), req,
                  loc_data, src_byte(m_strm[c], m_slot[c], k));
      end
      loc_valid = 1'b0; loc_fs = 1'b0;
      @(negedge clk);
      chk(loc_out_valid == 1'b0, "R8 idle", loc_out_valid, 0);
   endtask

   task automatic t_reset;
      chk(loc_data == 8'h00 && loc_out_valid == 1'b0, "R1 reset outputs", loc_data, 0);
      local_frame(0, 1'b1, 1'b1, "R1 bank zero");
      exp_beats(1, 0, 128, 1'b1);
      local_frame(1, 1'b1, 1'b0, "R1 default source");
   endtask

   task automatic t_program;
      for (int n = 0; n < 32; n++) begin
         host_write(1'b0, 'hA0 + n, 'h80 | ((n * 7 + 3) % 128));
         host_write(1'b1, 'hA0 + n, 'hF0 | ((n * 5) % 16));
      end
      exp_beats(2, 0, 128, 1'b1);
      local_frame(2, 1'b1, 1'b0, "R2 R3 R5 programmed map");
   endtask

   task automatic t_low_only;
      int before_slot;
      before_slot = m_slot[4];
      host_write(1'b0, 'hA4, 100);
      exp_beats(3, 0, 128, 1'b1);
      chk(m_slot[4] == before_slot, "R3 model", m_slot[4], before_slot);
      local_frame(3, 1'b1, 1'b0, "R3 low byte alone");
   endtask

   task automatic t_out_of_window;
      host_write(1'b0, 'h9F, 11);
      host_write(1'b1, 'hC0, 2);
      host_write(1'b1, 'h20, 7);
      exp_beats(4, 0, 128, 1'b1);
      local_frame(4, 1'b1, 1'b0, "R4 outside window");
      host_write(1'b1, 'hA5, 3);
      chk(m_slot[5] == 100, "R4 pending kept", m_slot[5], 100);
      exp_beats(5, 0, 128, 1'b1);
      local_frame(5, 1'b1, 1'b0, "R4 pending survives");
   endtask

   task automatic t_multicast;
      host_write(1'b0, 'hA0, 127);
      host_write(1'b1, 'hA0, 9);
      host_write(1'b1, 'hA1, 9);
      host_write(1'b0, 'hBF, 0);
      host_write(1'b1, 'hBF, 15);
      exp_beats(6, 0, 128, 1'b1);
      local_frame(6, 1'b1, 1'b0, "R5 shared and edge sources");
   endtask

   task automatic t_double_buffer;
      exp_beats(7, 0, 60, 1'b1);
      local_frame(6, 1'b1, 1'b0, "R6 partial frame hidden");
      exp_beats(7, 60, 67, 1'b0);
      local_frame(6, 1'b1, 1'b0, "R6 before last slot");
      exp_beats(7, 127, 1, 1'b0);
      local_frame(7, 1'b1, 1'b0, "R6 swap on last slot");
   endtask

   task automatic t_slot_count;
      exp_beats(8, 0, 128, 1'b0);
      local_frame(8, 1'b1, 1'b0, "R7 wrap without fs");
      exp_beats(9, 0, 30, 1'b1);
      exp_beats(10, 0, 128, 1'b1);
      local_frame(10, 1'b1, 1'b0, "R7 fs restarts count");
   endtask

   task automatic t_local_wrap;
      local_frame(10, 1'b1, 1'b0, "R8 first pass");
      local_frame(10, 1'b0, 1'b0, "R8 wrap after last channel");
      for (int c = 0; c < 5; c++) begin
         loc_valid = 1'b1; loc_fs = 1'b0; @(negedge clk);
      end
      loc_valid = 1'b1; loc_fs = 1'b1; @(negedge clk);
      loc_valid = 1'b0; loc_fs = 1'b0;
      chk(loc_data == src_byte(m_strm[0], m_slot[0], 10), "R8 fs mid-frame",
          loc_data, src_byte(m_strm[0], m_slot[0], 10));
      @(negedge clk);
   endtask

   initial begin
      for (int c = 0; c < 32; c++) begin m_strm[c] = 0; m_slot[c] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_program();
      t_low_only();
      t_out_of_window();
      t_multicast();
      t_double_buffer();
      t_slot_count();
      t_local_wrap();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            #(8 * 150000);
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule